// File: doc/BRIEF.md
# Boot-Time EDID Loader with SPI Pin Arbitration

This block fills the on-chip EDID memory from an external serial EEPROM as soon as the chip comes out of reset, so that the identification data is there before a video source asks for it. Once the power-down pin (`pwrdn_n`) goes high, the loader acts as SPI master without any host action. It issues a read of the full 256-byte image from address zero and writes each byte into the internal RAM through a one-cycle write port. When the read is done it lets go of the pins.

After the pins are released, the SPI pads belong to the on-screen-display slave path by default. A register bit from the host (`master_mode`) instead hands the pads to an on-chip host master. The loader takes the pads back only when asked. A reread request repeats the load. A store request writes the RAM image back to the EEPROM one 16-byte page at a time, each page preceded by a write-enable command and followed by status polling. A request that arrives while an operation runs is held, and it starts as soon as that operation ends, without the pins being released in between.

Top module: `edid_boot_loader`

## Requirements
- R1: After reset the loader owns the pins (`busy`=1, `cs_n_o`=1 with `cs_n_oe`=1, `sclk_o`=0). It starts the load by itself once `pwrdn_n` is high; while `pwrdn_n` stays low it never pulls chip select low. No request input is needed.
- R2: A load is one chip-select-low transfer: opcode 0x03, then three address bytes 0x00, 0x00, 0x00, then data. It uses SPI mode 0: SCLK idles low while chip select is high, bits go MSB first, MOSI changes only while SCLK is low, and MISO is sampled on the rising edge.
- R3: The 256 data bytes of a load are written in order to RAM addresses 0 to 255, one `ram_we` pulse each, with `ram_wdata` equal to the byte read. `ram_we` is only ever high while `busy` is high.
- R4: The startup load ends (`busy` falls) within 260*(16*CLK_DIV+4)+16 clock cycles after `pwrdn_n` rises.
- R5: While `busy` is high, all three output enables are high and the slave path is blocked: `slv_cs_n` is 1 whatever `pad_cs_n_i` is.
- R6: While idle with `master_mode`=0, all output enables are low, `cs_n_o` is 1, and `slv_sclk`, `slv_cs_n` and `slv_mosi` follow the pad inputs.
- R7: While idle with `master_mode`=1, `sclk_o`, `cs_n_o` and `mosi_o` follow the `host_*` inputs with their enables high, and `slv_cs_n` is 1.
- R8: Once released, the loader never raises `busy` or drives chip select low again unless a reread or store request has been received.
- R9: A one-cycle `reread_req` repeats the load, so the RAM then holds the EEPROM's current contents.
- R10: A one-cycle `store_req` writes the RAM image back page by page, in ascending order, 16 bytes per page. Each page gets a write-enable transfer (0x06), then a page-program transfer (0x02, 24-bit address page*16, 16 bytes read from `ram_rdata` while the block drives `ram_addr`, where `ram_rdata` is a same-cycle combinational read), then status-read transfers (0x05) repeated until status bit 0 is 0.
- R11: A request that arrives while an operation runs is queued and starts when that operation ends, with `busy` held high throughout. When both requests are pending, the reread runs first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwrdn_n | input | 1 | Power-down pin level; the startup load waits for it to be high |
| reread_req | input | 1 | One-cycle request to reload the EDID image |
| store_req | input | 1 | One-cycle request to write the EDID image back |
| master_mode | input | 1 | Host register bit: 1 gives idle pads to the host master |
| host_sclk | input | 1 | Host master clock |
| host_cs_n | input | 1 | Host master chip select |
| host_mosi | input | 1 | Host master data out |
| pad_sclk_i | input | 1 | SCLK pad input, used in slave mode |
| pad_cs_n_i | input | 1 | Chip-select pad input, used in slave mode |
| pad_mosi_i | input | 1 | MOSI pad input, used in slave mode |
| miso_i | input | 1 | MISO from the EEPROM |
| sclk_o | output | 1 | SCLK pad output |
| sclk_oe | output | 1 | SCLK pad output enable |
| cs_n_o | output | 1 | Chip-select pad output |
| cs_n_oe | output | 1 | Chip-select pad output enable |
| mosi_o | output | 1 | MOSI pad output |
| mosi_oe | output | 1 | MOSI pad output enable |
| slv_sclk | output | 1 | Clock to the OSD slave |
| slv_cs_n | output | 1 | Chip select to the OSD slave (1 when blocked) |
| slv_mosi | output | 1 | Data to the OSD slave |
| ram_we | output | 1 | EDID RAM write strobe |
| ram_addr | output | 8 | EDID RAM address (write and read) |
| ram_wdata | output | 8 | EDID RAM write data |
| ram_rdata | input | 8 | EDID RAM read data for the addressed byte, same cycle |
| busy | output | 1 | Loader owns the pins |

## Verification
The main function, moving the image between the EEPROM and the RAM, is exercised with three different EEPROM patterns: an address-derived pattern at startup, then a changed pattern and a further one for the rereads. This separates a real refresh from stale data and shows up byte-order or address-offset slips. The store test starts with RAM and EEPROM deliberately different and holds the EEPROM busy for two polls after each page. That separates correct page addressing and correct poll looping from a loader that ignores the busy bit. Issuing both requests together from idle shows the queue order and that the pins stay claimed across the two operations. The quiet interval with slave traffic on the pads shows that the loader does not reclaim the bus on its own.

// File: rtl/edid_ldr_pkg.sv
package edid_ldr_pkg;

  typedef enum logic [1:0] {K_READ, K_WREN, K_PP, K_RDSR} xfer_kind_e;
  typedef enum logic [1:0] {OWN_LOADER, OWN_HOST, OWN_SLAVE} pin_owner_e;

  localparam logic [7:0] OPC_READ = 8'h03;
  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_PP   = 8'h02;
  localparam logic [7:0] OPC_RDSR = 8'h05;

  // bytes on the wire for one chip-select-low transfer
  function automatic int unsigned xfer_len(xfer_kind_e k, int unsigned img, int unsigned pg);
    case (k)
      K_READ:  return 4 + img;
      K_WREN:  return 1;
      K_PP:    return 4 + pg;
      default: return 2;
    endcase
  endfunction

  function automatic logic [7:0] opcode_of(xfer_kind_e k);
    case (k)
      K_READ:  return OPC_READ;
      K_WREN:  return OPC_WREN;
      K_PP:    return OPC_PP;
      default: return OPC_RDSR;
    endcase
  endfunction

  // byte sent at position idx of a transfer
  function automatic logic [7:0] tx_byte(xfer_kind_e k, int unsigned idx,
                                         logic [23:0] addr, logic [7:0] rdata);
    if (idx == 0) return opcode_of(k);
    if (k == K_WREN || k == K_RDSR) return 8'h00;
    case (idx)
      1:       return addr[23:16];
      2:       return addr[15:8];
      3:       return addr[7:0];
      default: return (k == K_PP) ? rdata : 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/edid_spi_shifter.sv
module edid_spi_shifter #(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx
);
  localparam int unsigned DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [DW-1:0] div_q;
  logic [2:0]    bit_q;
  logic [7:0]    tx_q, rx_q;
  logic          sclk_q, act_q, done_q;
  logic          half_end;

  assign half_end = (div_q == DW'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0; bit_q <= '0; tx_q <= '0; rx_q <= '0;
      sclk_q <= 1'b0; act_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!act_q) begin
        if (start) begin
          act_q <= 1'b1; tx_q <= tx; bit_q <= '0; div_q <= '0; sclk_q <= 1'b0;
        end
      end else if (half_end) begin
        div_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[6:0], miso};
        end else begin
          sclk_q <= 1'b0;
          if (bit_q == 3'd7) begin
            act_q  <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 3'd1;
            tx_q  <= {tx_q[6:0], 1'b0};
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign sclk = sclk_q;
  assign mosi = tx_q[7];
  assign done = done_q;
  assign rx   = rx_q;
endmodule

// File: rtl/edid_load_seq.sv
module edid_load_seq
  import edid_ldr_pkg::*;
#(
  parameter int unsigned EDID_BYTES = 256,
  parameter int unsigned PAGE_BYTES = 16,
  localparam int unsigned AW = $clog2(EDID_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwrdn_n,
  input  logic          reread_req,
  input  logic          store_req,
  input  logic          eng_done,
  input  logic [7:0]    eng_rx,
  input  logic [7:0]    ram_rdata,
  output logic          eng_start,
  output logic [7:0]    eng_tx,
  output logic          cs_n,
  output logic          busy,
  output logic          pend_any,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_wdata
);
  localparam int unsigned PAGES = EDID_BYTES / PAGE_BYTES;
  localparam int unsigned PW    = (PAGES > 1) ? $clog2(PAGES) : 1;
  localparam int unsigned CW    = $clog2(EDID_BYTES + 5);

  typedef enum logic [1:0] {S_WAIT, S_XFER, S_GAP, S_IDLE} seq_state_e;

  seq_state_e  state_q;
  xfer_kind_e  kind_q, gap_kind;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] page_q;
  logic        kick_q, stat_q, pend_rr_q, pend_st_q;
  logic        gap_fin, gap_page_inc, last_byte;
  logic [23:0] pbase;

  assign pbase     = 24'(32'(page_q) * PAGE_BYTES);
  assign last_byte = (32'(cnt_q) == xfer_len(kind_q, EDID_BYTES, PAGE_BYTES) - 1);
  assign eng_start = (state_q == S_XFER) && kick_q;
  assign eng_tx    = tx_byte(kind_q, 32'(cnt_q), (kind_q == K_PP) ? pbase : 24'd0, ram_rdata);
  assign ram_addr  = AW'(((kind_q == K_PP) ? 32'(pbase) : 32'd0) + 32'(cnt_q) - 32'd4);
  assign ram_we    = (state_q == S_XFER) && eng_done && (kind_q == K_READ) && (cnt_q >= CW'(4));
  assign ram_wdata = eng_rx;
  assign cs_n      = (state_q != S_XFER);
  assign busy      = (state_q != S_IDLE);
  assign pend_any  = pend_rr_q | pend_st_q;

  // what follows the transfer that just ended
  always_comb begin
    gap_kind = K_READ; gap_fin = 1'b0; gap_page_inc = 1'b0;
    case (kind_q)
      K_READ: gap_fin = 1'b1;
      K_WREN: gap_kind = K_PP;
      K_PP:   gap_kind = K_RDSR;
      default: begin
        if (stat_q)                          gap_kind = K_RDSR;
        else if (page_q == PW'(PAGES - 1))   gap_fin  = 1'b1;
        else begin gap_kind = K_WREN; gap_page_inc = 1'b1; end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_WAIT; kind_q <= K_READ; cnt_q <= '0; page_q <= '0;
      kick_q <= 1'b0; stat_q <= 1'b0; pend_rr_q <= 1'b0; pend_st_q <= 1'b0;
    end else begin
      pend_rr_q <= pend_rr_q | reread_req;
      pend_st_q <= pend_st_q | store_req;
      case (state_q)
        S_WAIT: if (pwrdn_n) begin
          state_q <= S_XFER; kind_q <= K_READ; cnt_q <= '0; kick_q <= 1'b1;
        end
        S_XFER: begin
          kick_q <= 1'b0;
          if (eng_done) begin
            if (kind_q == K_RDSR) stat_q <= eng_rx[0];
            if (last_byte) state_q <= S_GAP;
            else begin cnt_q <= cnt_q + 1'b1; kick_q <= 1'b1; end
          end
        end
        default: begin
          if (state_q == S_GAP && !gap_fin) begin
            kind_q <= gap_kind; state_q <= S_XFER; cnt_q <= '0; kick_q <= 1'b1;
            if (gap_page_inc) page_q <= page_q + 1'b1;
          end else if (pend_rr_q) begin
            pend_rr_q <= reread_req;
            kind_q <= K_READ; state_q <= S_XFER; cnt_q <= '0; kick_q <= 1'b1;
          end else if (pend_st_q) begin
            pend_st_q <= store_req;
            kind_q <= K_WREN; page_q <= '0; state_q <= S_XFER; cnt_q <= '0; kick_q <= 1'b1;
          end else begin
            state_q <= S_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/edid_pin_owner.sv
module edid_pin_owner
  import edid_ldr_pkg::*;
(
  input  logic loader_busy,
  input  logic master_sel,
  input  logic ldr_sclk,
  input  logic ldr_cs_n,
  input  logic ldr_mosi,
  input  logic host_sclk,
  input  logic host_cs_n,
  input  logic host_mosi,
  input  logic pad_sclk_i,
  input  logic pad_cs_n_i,
  input  logic pad_mosi_i,
  output logic sclk_o,
  output logic sclk_oe,
  output logic cs_n_o,
  output logic cs_n_oe,
  output logic mosi_o,
  output logic mosi_oe,
  output logic slv_sclk,
  output logic slv_cs_n,
  output logic slv_mosi
);
  pin_owner_e owner;

  assign owner = loader_busy ? OWN_LOADER : (master_sel ? OWN_HOST : OWN_SLAVE);

  always_comb begin
    sclk_o = 1'b0; cs_n_o = 1'b1; mosi_o = 1'b0;
    sclk_oe = 1'b0; cs_n_oe = 1'b0; mosi_oe = 1'b0;
    slv_sclk = 1'b0; slv_cs_n = 1'b1; slv_mosi = 1'b0;
    case (owner)
      OWN_LOADER: begin
        sclk_o = ldr_sclk; cs_n_o = ldr_cs_n; mosi_o = ldr_mosi;
        sclk_oe = 1'b1; cs_n_oe = 1'b1; mosi_oe = 1'b1;
      end
      OWN_HOST: begin
        sclk_o = host_sclk; cs_n_o = host_cs_n; mosi_o = host_mosi;
        sclk_oe = 1'b1; cs_n_oe = 1'b1; mosi_oe = 1'b1;
      end
      default: begin
        slv_sclk = pad_sclk_i; slv_cs_n = pad_cs_n_i; slv_mosi = pad_mosi_i;
      end
    endcase
  end
endmodule

// File: rtl/edid_boot_loader.sv
module edid_boot_loader #(
  parameter int unsigned CLK_DIV    = 4,
  parameter int unsigned EDID_BYTES = 256,
  parameter int unsigned PAGE_BYTES = 16,
  localparam int unsigned AW = $clog2(EDID_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwrdn_n,
  input  logic          reread_req,
  input  logic          store_req,
  input  logic          master_mode,
  input  logic          host_sclk,
  input  logic          host_cs_n,
  input  logic          host_mosi,
  input  logic          pad_sclk_i,
  input  logic          pad_cs_n_i,
  input  logic          pad_mosi_i,
  input  logic          miso_i,
  output logic          sclk_o,
  output logic          sclk_oe,
  output logic          cs_n_o,
  output logic          cs_n_oe,
  output logic          mosi_o,
  output logic          mosi_oe,
  output logic          slv_sclk,
  output logic          slv_cs_n,
  output logic          slv_mosi,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_wdata,
  input  logic [7:0]    ram_rdata,
  output logic          busy
);
  logic       eng_start, eng_done, eng_sclk, eng_mosi, seq_cs_n, pend_any;
  logic [7:0] eng_tx, eng_rx;

  edid_spi_shifter #(.CLK_DIV(CLK_DIV)) i_shift (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .tx(eng_tx), .miso(miso_i),
    .sclk(eng_sclk), .mosi(eng_mosi), .done(eng_done), .rx(eng_rx)
  );

  edid_load_seq #(.EDID_BYTES(EDID_BYTES), .PAGE_BYTES(PAGE_BYTES)) i_seq (
    .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .reread_req(reread_req),
    .store_req(store_req), .eng_done(eng_done), .eng_rx(eng_rx), .ram_rdata(ram_rdata),
    .eng_start(eng_start), .eng_tx(eng_tx), .cs_n(seq_cs_n), .busy(busy),
    .pend_any(pend_any), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

  edid_pin_owner i_own (
    .loader_busy(busy), .master_sel(master_mode),
    .ldr_sclk(eng_sclk), .ldr_cs_n(seq_cs_n), .ldr_mosi(eng_mosi),
    .host_sclk(host_sclk), .host_cs_n(host_cs_n), .host_mosi(host_mosi),
    .pad_sclk_i(pad_sclk_i), .pad_cs_n_i(pad_cs_n_i), .pad_mosi_i(pad_mosi_i),
    .sclk_o(sclk_o), .sclk_oe(sclk_oe), .cs_n_o(cs_n_o), .cs_n_oe(cs_n_oe),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .slv_sclk(slv_sclk), .slv_cs_n(slv_cs_n), .slv_mosi(slv_mosi)
  );
endmodule

// File: rtl/edid_boot_loader_chk.sv
module edid_boot_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic master_mode,
  input logic pend_any,
  input logic sclk_o,
  input logic sclk_oe,
  input logic cs_n_o,
  input logic cs_n_oe,
  input logic mosi_o,
  input logic mosi_oe,
  input logic slv_cs_n,
  input logic ram_we
);
  // R6
  release_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !master_mode) |-> (!sclk_oe && !cs_n_oe && !mosi_oe && cs_n_o));

  // R5
  loader_owns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (sclk_oe && cs_n_oe && mosi_oe && slv_cs_n));

  // R8
  no_reclaim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(pend_any));

  // R3
  ram_we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> busy);

  // R2
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cs_n_o) |-> !sclk_o);

  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sclk_o && $past(sclk_o)) |-> $stable(mosi_o));
endmodule

bind edid_boot_loader edid_boot_loader_chk i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .master_mode(master_mode), .pend_any(pend_any),
  .sclk_o(sclk_o), .sclk_oe(sclk_oe), .cs_n_o(cs_n_o), .cs_n_oe(cs_n_oe),
  .mosi_o(mosi_o), .mosi_oe(mosi_oe), .slv_cs_n(slv_cs_n), .ram_we(ram_we)
);

// File: tb/test_edid_boot_loader.sv
`timescale 1ns/1ps
module test_edid_boot_loader;
  localparam int DIV = 4;
  localparam int LOAD_BOUND = 260 * (16 * DIV + 4) + 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0, pwrdn_n = 1'b0, reread_req = 1'b0, store_req = 1'b0, master_mode = 1'b0;
  logic host_sclk = 1'b0, host_cs_n = 1'b1, host_mosi = 1'b0;
  logic pad_sclk_i = 1'b0, pad_cs_n_i = 1'b1, pad_mosi_i = 1'b0;
  logic miso = 1'b0;
  logic sclk_o, sclk_oe, cs_n_o, cs_n_oe, mosi_o, mosi_oe;
  logic slv_sclk, slv_cs_n, slv_mosi, ram_we, busy;
  logic [7:0] ram_addr, ram_wdata, ram_rdata;

  logic [7:0] eep [256];
  logic [7:0] ram [256];
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  edid_boot_loader #(.CLK_DIV(DIV)) i_edid_boot_loader (
    .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .reread_req(reread_req),
    .store_req(store_req), .master_mode(master_mode),
    .host_sclk(host_sclk), .host_cs_n(host_cs_n), .host_mosi(host_mosi),
    .pad_sclk_i(pad_sclk_i), .pad_cs_n_i(pad_cs_n_i), .pad_mosi_i(pad_mosi_i),
    .miso_i(miso), .sclk_o(sclk_o), .sclk_oe(sclk_oe), .cs_n_o(cs_n_o), .cs_n_oe(cs_n_oe),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .slv_sclk(slv_sclk), .slv_cs_n(slv_cs_n),
    .slv_mosi(slv_mosi), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .busy(busy)
  );

  // RAM model with write-order monitor
  logic [7:0] we_expect = 8'd0;
  int order_err = 0;
  assign ram_rdata = ram[ram_addr];
  always @(posedge clk) if (ram_we) begin
    ram[ram_addr] <= ram_wdata;
    if (ram_addr != we_expect) order_err++;
    we_expect <= we_expect + 8'd1;
  end

  // EEPROM model and bus monitors
  logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_mosi = 1'b0, prev_busy = 1'b1;
  logic [7:0] in_sh = 8'd0, out_sh = 8'd0, cmd = 8'd0;
  int bi = 0, nbit = 0, addr = 0, wip = 0, pp_page = 0;
  logic wel = 1'b0;
  int cs_falls = 0, n_read = 0, n_wren = 0, n_pp = 0, n_rdsr = 0;
  int rd_addr_err = 0, pp_addr_err = 0, mode_err = 0, busy_falls = 0, busy_rises = 0;
  logic [7:0] first_op = 8'd0;
  logic arm_first = 1'b0;
  logic cs_eff, sclk_eff;
  assign cs_eff   = cs_n_oe ? cs_n_o : 1'b1;
  assign sclk_eff = sclk_oe ? sclk_o : 1'b0;

  always @(negedge clk) begin
    if (busy && cs_n_o && sclk_o) mode_err++;
    if (busy && sclk_o && prev_sclk && (mosi_o != prev_mosi)) mode_err++;
    if (prev_busy && !busy) busy_falls++;
    if (!prev_busy && busy) busy_rises++;
    if (prev_cs && !cs_eff) begin bi = 0; nbit = 0; addr = 0; cmd = 8'd0; cs_falls++; end
    if (!prev_cs && cs_eff && cmd == 8'h02 && wel) begin wel = 1'b0; wip = 2; pp_page++; end
    if (!cs_eff) begin
      if (!prev_sclk && sclk_eff) begin
        in_sh = {in_sh[6:0], mosi_o};
        nbit++;
        if (nbit == 8) begin
          nbit = 0;
          if (bi == 0) begin
            cmd = in_sh;
            if (arm_first) begin first_op = in_sh; arm_first = 1'b0; end
            case (in_sh)
              8'h03: n_read++;
              8'h06: begin n_wren++; wel = 1'b1; end
              8'h02: n_pp++;
              8'h05: begin n_rdsr++; out_sh = {7'd0, wip != 0}; if (wip > 0) wip--; end
              default: ;
            endcase
          end else if (bi <= 3) begin
            addr = (addr << 8) | int'(in_sh);
            if (bi == 3 && cmd == 8'h03) begin
              if (addr != 0) rd_addr_err++;
              out_sh = eep[addr % 256]; addr++;
            end
            if (bi == 3 && cmd == 8'h02 && addr != pp_page * 16) pp_addr_err++;
          end else begin
            if (cmd == 8'h03) begin out_sh = eep[addr % 256]; addr++; end
            if (cmd == 8'h02 && wel) begin
              eep[addr % 256] = in_sh;
              addr = (addr & ~15) | ((addr + 1) & 15);
            end
          end
          bi++;
        end
      end
      if (prev_sclk && !sclk_eff) begin miso = out_sh[7]; out_sh = {out_sh[6:0], 1'b0}; end
    end
    prev_cs = cs_eff; prev_sclk = sclk_eff; prev_mosi = mosi_o; prev_busy = busy;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    @(negedge clk);
    while (busy && cyc < 60000) begin @(negedge clk); cyc++; end
  endtask

  task automatic ram_mismatch(output int n);
    n = 0;
    for (int i = 0; i < 256; i++) if (ram[i] !== eep[i]) n++;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; pwrdn_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    pad_cs_n_i = 1'b0;
    repeat (50) @(negedge clk);
    chk(busy == 1'b1, "R1 busy after reset", busy, 1);
    chk(cs_n_o == 1'b1 && cs_n_oe == 1'b1 && sclk_o == 1'b0, "R1 idle pins", {cs_n_o, cs_n_oe, sclk_o}, 3'b110);
    chk(cs_falls == 0, "R1 no transfer while pwrdn_n low", cs_falls, 0);
    chk(slv_cs_n == 1'b1, "R5 slave blocked while waiting", slv_cs_n, 1);
    pad_cs_n_i = 1'b1;
  endtask

  task automatic t_startup;
    int cyc, mm;
    for (int i = 0; i < 256; i++) eep[i] = 8'(i * 7 + 3);
    @(negedge clk); pwrdn_n = 1'b1;
    wait_idle(cyc);
    chk(cyc <= LOAD_BOUND, "R4 startup load time", cyc, LOAD_BOUND);
    chk(n_read == 1 && cs_falls == 1, "R2 one read transfer", n_read, 1);
    chk(rd_addr_err == 0, "R2 read address zero", rd_addr_err, 0);
    chk(mode_err == 0, "R2 mode 0 timing", mode_err, 0);
    ram_mismatch(mm);
    chk(mm == 0, "R3 RAM matches EEPROM", mm, 0);
    chk(order_err == 0, "R3 RAM write order", order_err, 0);
  endtask

  task automatic t_slave;
    master_mode = 1'b0;
    pad_sclk_i = 1'b1; pad_cs_n_i = 1'b0; pad_mosi_i = 1'b1;
    @(negedge clk);
    chk({sclk_oe, cs_n_oe, mosi_oe} == 3'b000 && cs_n_o == 1'b1, "R6 released pins", {sclk_oe, cs_n_oe, mosi_oe, cs_n_o}, 1);
    chk({slv_sclk, slv_cs_n, slv_mosi} == 3'b101, "R6 slave follows pads", {slv_sclk, slv_cs_n, slv_mosi}, 5);
    pad_sclk_i = 1'b0; pad_cs_n_i = 1'b1; pad_mosi_i = 1'b0;
    @(negedge clk);
    chk({slv_sclk, slv_cs_n, slv_mosi} == 3'b010, "R6 slave follows pads low", {slv_sclk, slv_cs_n, slv_mosi}, 2);
  endtask

  task automatic t_master;
    master_mode = 1'b1; host_sclk = 1'b1; host_cs_n = 1'b0; host_mosi = 1'b1; pad_cs_n_i = 1'b0;
    @(negedge clk);
    chk({sclk_o, cs_n_o, mosi_o} == 3'b101 && {sclk_oe, cs_n_oe, mosi_oe} == 3'b111,
        "R7 host drives pads", {sclk_o, cs_n_o, mosi_o}, 5);
    chk(slv_cs_n == 1'b1, "R7 slave blocked in master mode", slv_cs_n, 1);
    master_mode = 1'b0; host_sclk = 1'b0; host_cs_n = 1'b1; host_mosi = 1'b0; pad_cs_n_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_quiet;
    int f0, r0;
    f0 = cs_falls; r0 = busy_rises;
    for (int i = 0; i < 1500; i++) begin
      pad_cs_n_i = i[3]; pad_sclk_i = i[0];
      @(negedge clk);
    end
    pad_cs_n_i = 1'b1; pad_sclk_i = 1'b0;
    chk(busy_rises == r0 && busy == 1'b0, "R8 no reclaim without request", busy_rises - r0, 0);
    chk(cs_falls == f0, "R8 no chip select activity", cs_falls - f0, 0);
  endtask

  task automatic t_reread;
    int cyc, mm, r0;
    r0 = n_read;
    for (int i = 0; i < 256; i++) eep[i] = 8'(255 - i) ^ 8'h5A;
    @(negedge clk); reread_req = 1'b1; @(negedge clk); reread_req = 1'b0;
    repeat (20) @(negedge clk);
    pad_cs_n_i = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1 && slv_cs_n == 1'b1, "R5 slave blocked during reread", slv_cs_n, 1);
    pad_cs_n_i = 1'b1;
    wait_idle(cyc);
    ram_mismatch(mm);
    chk(mm == 0, "R9 RAM refreshed", mm, 0);
    chk(n_read == r0 + 1, "R9 one more read", n_read, r0 + 1);
  endtask

  task automatic t_store;
    int cyc, mm;
    for (int i = 0; i < 256; i++) begin ram[i] = 8'(i * 13 + 1); eep[i] = 8'hFF; end
    n_wren = 0; n_pp = 0; n_rdsr = 0; pp_page = 0;
    @(negedge clk); store_req = 1'b1; @(negedge clk); store_req = 1'b0;
    wait_idle(cyc);
    ram_mismatch(mm);
    chk(mm == 0, "R10 EEPROM holds RAM image", mm, 0);
    chk(n_wren == 16 && n_pp == 16, "R10 WREN and PP per page", n_pp, 16);
    chk(n_rdsr == 48, "R10 status polls until ready", n_rdsr, 48);
    chk(pp_addr_err == 0, "R10 page addresses ascending", pp_addr_err, 0);
  endtask

  task automatic t_queue;
    int cyc, mm, f0, r0;
    for (int i = 0; i < 256; i++) eep[i] = 8'(i ^ 8'hA5);
    n_pp = 0; pp_page = 0; r0 = n_read; f0 = busy_falls;
    arm_first = 1'b1;
    @(negedge clk); reread_req = 1'b1; store_req = 1'b1;
    @(negedge clk); reread_req = 1'b0; store_req = 1'b0;
    wait_idle(cyc);
    chk(first_op == 8'h03, "R11 reread runs first", first_op, 3);
    chk(n_read == r0 + 1 && n_pp == 16, "R11 both operations ran", n_pp, 16);
    chk(busy_falls == f0 + 1, "R11 bus held across queued ops", busy_falls - f0, 1);
    ram_mismatch(mm);
    chk(mm == 0, "R11 image consistent", mm, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset;
    t_startup;
    t_slave;
    t_master;
    t_quiet;
    t_reread;
    t_store;
    t_queue;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule